// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

This block takes one fast source clock and produces two independent divided clock banks, A and B. Each bank owns a 6-bit ratio code. Each bank drives four copies of its divided clock, and all four copies come from one register. The division ratio is twice the code. The one exception is code 7, which gives an odd ratio of 15. That ratio is built from both edges of the source clock so that its duty cycle stays close to one half.

An active-high master reset and an external lock indication govern the outputs. Outputs stay low while reset is high or lock is low. Once both conditions clear, and after a short synchroniser on the lock input, each bank begins a new period with a clean full-width high phase. A new code is sampled only where an output period ends, so a change made mid-period cannot produce a runt pulse. Codes below 4 are rejected: the bank keeps its outputs low and raises an error flag.

All pins are plain control or clock pins. There is no data stream, so no valid/ready handshake exists and no back-pressure applies.

Top module: `clk_bank_divider`

## Requirements
- R1: For a code c with 4 <= c <= 63 and c != 7, every output of the bank has a period of 2c source cycles, high for exactly c cycles and low for exactly c cycles.
- R2: Code 7 gives a period of 15 source cycles, high for 7.5 cycles and low for 7.5 cycles, using both source clock edges.
- R3: Codes 0 to 3 are illegal. While one is in effect, the bank's error flag reads 1 and all four of its outputs stay 0. A legal code sampled later returns the flag to 0.
- R4: All outputs read 0 whenever master reset is 1 or the lock input is 0.
- R5: After reset release with lock present, or after lock returns, the first output pulse of a bank is a full-width high phase of the code in effect.
- R6: A code written mid-period takes effect only after the current period has completed. No output pulse is shorter than half the smaller of the old and new periods.
- R7: The four copies of one bank are identical at every instant.
- R8: The two banks run independently. The code or error state of one bank does not change the other bank's waveform.
- R9: Master reset clears both error flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | High-rate source clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| lock_in | input | 1 | Lock indication, 1 = source clock usable |
| cfg_a | input | 6 | Ratio code for bank A |
| cfg_b | input | 6 | Ratio code for bank B |
| out_a | output | 4 | Four copies of the bank A divided clock |
| out_b | output | 4 | Four copies of the bank B divided clock |
| cfg_err_a | output | 1 | 1 while bank A holds an illegal code |
| cfg_err_b | output | 1 | 1 while bank B holds an illegal code |

## Verification
The assertions check, on every cycle, the properties that hold at each edge:
- the period counter stays inside the period of the code in effect;
- the active code is held until the period ends;
- a fresh high phase starts only at count zero;
- an idle or erroneous bank keeps its internal output low;
- the four copies agree.

Only the bench's scenarios can show the waveform properties. These are the measured high and low widths, in half source cycles, for every legal code including the 7.5-cycle phases of code 7. They also include the pulse widths around a code change made mid-period, the full first pulse after lock returns, and the independence of the two banks.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int CODE_W   = 6;
  localparam int CNT_W    = CODE_W + 1;
  localparam int MIN_CODE = 4;
  localparam int ODD_CODE = 7;
  localparam int ODD_HI   = 8;   // posedge-domain high count for the odd ratio
  localparam int ODD_LAST = 14;  // last count of a 15-cycle period
  localparam int BAD_LAST = 7;   // period used to resample an illegal code

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic logic code_ok(code_t c);
    return c >= code_t'(MIN_CODE);
  endfunction

  function automatic logic code_odd(code_t c);
    return c == code_t'(ODD_CODE);
  endfunction

  // number of posedge cycles the phase register stays high
  function automatic cnt_t hi_len(code_t c);
    if (!code_ok(c))       return '0;
    else if (code_odd(c))  return cnt_t'(ODD_HI);
    else                   return {1'b0, c};
  endfunction

  // terminal count of one output period
  function automatic cnt_t last_cnt(code_t c);
    if (!code_ok(c))       return cnt_t'(BAD_LAST);
    else if (code_odd(c))  return cnt_t'(ODD_LAST);
    else                   return {c, 1'b0} - cnt_t'(1);
  endfunction
endpackage

// File: rtl/cbd_enable.sv
module cbd_enable #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_in,
  output logic run,
  output logic gate
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '0;
        else     sync_q <= lock_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge rst) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], lock_in};
      end
    end
  endgenerate

  assign run  = sync_q[MSB];
  assign gate = ~rst & lock_in & run;

  AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(sync_q[0])) else $error("run rose without lock"); // R5
endmodule

// File: rtl/cbd_bank.sv
module cbd_bank
  import cbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  gate,
  input  code_t cfg,
  output logic  clk_div,
  output logic  cfg_err
);
  cnt_t  cnt;
  code_t cur;
  logic  pend;     // next running edge opens a fresh period
  logic  ph_pos;   // phase register, posedge domain
  logic  ph_neg;   // same phase delayed half a source cycle
  logic  odd_q;
  logic  at_end;
  cnt_t  cnt_nx;

  assign at_end = (cnt == last_cnt(cur));
  assign cnt_nx = cnt + cnt_t'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt     <= '0;
      cur     <= '0;
      pend    <= 1'b1;
      ph_pos  <= 1'b0;
      odd_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      pend   <= 1'b1;
      ph_pos <= 1'b0;
    end else if (pend || at_end) begin
      cnt     <= '0;
      cur     <= cfg;
      pend    <= 1'b0;
      ph_pos  <= code_ok(cfg);
      odd_q   <= code_odd(cfg);
      cfg_err <= ~code_ok(cfg);
    end else begin
      cnt    <= cnt_nx;
      ph_pos <= code_ok(cur) && (cnt_nx < hi_len(cur));
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) ph_neg <= 1'b0;
    else     ph_neg <= ph_pos;
  end

  assign clk_div = gate & ph_pos & (odd_q ? ph_neg : 1'b1);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (run && !pend) |-> (cnt <= last_cnt(cur))) else $error("count overrun"); // R1
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (run && !pend && !at_end) |=> $stable(cur)) else $error("code changed mid-period"); // R6
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_pos) |-> (cnt == '0)) else $error("high phase began mid-period"); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !ph_pos) else $error("illegal code drove output"); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ph_pos) else $error("idle bank kept phase high"); // R4
endmodule

// File: rtl/cbd_fanout.sv
module cbd_fanout #(
  parameter int COPIES = 4
) (
  input  logic              src,
  output logic [COPIES-1:0] dst
);
  generate
    for (genvar i = 0; i < COPIES; i++) begin : g_copy
      assign dst[i] = src;
    end
  endgenerate
endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
  import cbd_pkg::*;
#(
  parameter int COPIES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_src,
  input  logic              rst,
  input  logic              lock_in,
  input  logic [CODE_W-1:0] cfg_a,
  input  logic [CODE_W-1:0] cfg_b,
  output logic [COPIES-1:0] out_a,
  output logic [COPIES-1:0] out_b,
  output logic              cfg_err_a,
  output logic              cfg_err_b
);
  localparam int BANKS = 2;

  logic  run;
  logic  gate;
  code_t cfg_arr [BANKS];
  logic  div_arr [BANKS];
  logic  err_arr [BANKS];
  logic [COPIES-1:0] out_arr [BANKS];

  assign cfg_arr[0] = cfg_a;
  assign cfg_arr[1] = cfg_b;

  cbd_enable #(.SYNC_STAGES(SYNC_STAGES)) u_en (
    .clk(clk_src), .rst(rst), .lock_in(lock_in), .run(run), .gate(gate)
  );

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      cbd_bank u_bank (
        .clk(clk_src), .rst(rst), .run(run), .gate(gate),
        .cfg(cfg_arr[b]), .clk_div(div_arr[b]), .cfg_err(err_arr[b])
      );
      cbd_fanout #(.COPIES(COPIES)) u_fan (
        .src(div_arr[b]), .dst(out_arr[b])
      );
    end
  endgenerate

  assign out_a     = out_arr[0];
  assign out_b     = out_arr[1];
  assign cfg_err_a = err_arr[0];
  assign cfg_err_b = err_arr[1];

  AST_COPIES_MATCH: assert property (@(posedge clk_src) disable iff (rst)
    ((out_a == '0) || (out_a == '1)) && ((out_b == '0) || (out_b == '1)))
    else $error("bank copies disagree"); // R7
  AST_ERR_OUT_LOW: assert property (@(posedge clk_src) disable iff (rst)
    (cfg_err_a |-> (out_a == '0)) and (cfg_err_b |-> (out_b == '0)))
    else $error("error bank toggling"); // R3
endmodule

// File: tb/sim_clk_bank_divider.sv
module sim_clk_bank_divider;
  logic       clk = 1'b0;
  logic       rst;
  logic       lock_in;
  logic [5:0] cfg_a, cfg_b;
  logic [3:0] out_a, out_b;
  logic       cfg_err_a, cfg_err_b;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;   // 50 MHz

  clk_bank_divider u0 (
    .clk_src(clk), .rst(rst), .lock_in(lock_in), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .out_a(out_a), .out_b(out_b), .cfg_err_a(cfg_err_a), .cfg_err_b(cfg_err_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (270) @(posedge clk);
  endtask

  // sample 2 ns after every source edge: one sample per half cycle
  task automatic step(input bit sel, output logic v, output logic cp);
    @(posedge clk or negedge clk);
    #2;
    v  = sel ? out_b[0] : out_a[0];
    cp = sel ? ((out_b == 4'h0) || (out_b == 4'hf)) : ((out_a == 4'h0) || (out_a == 4'hf));
  endtask

  // waits for a rising output, then measures one high and one low phase in half cycles
  task automatic measure(input bit sel, output int hi, output int lo, output bit cp_ok);
    logic v, cp, pv;
    cp_ok = 1'b1;
    pv = 1'b1;
    forever begin
      step(sel, v, cp); if (!cp) cp_ok = 1'b0;
      if (!pv && v) break;
      pv = v;
    end
    hi = 1;
    forever begin
      step(sel, v, cp); if (!cp) cp_ok = 1'b0;
      if (v) hi++; else break;
    end
    lo = 1;
    forever begin
      step(sel, v, cp); if (!cp) cp_ok = 1'b0;
      if (!v) lo++; else break;
    end
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    #2;
    chk("R4", "out_a in reset", int'(out_a), 0);
    chk("R4", "out_b in reset", int'(out_b), 0);
    chk("R9", "err flags in reset", int'({cfg_err_a, cfg_err_b}), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R4", "outputs without lock", int'({out_a, out_b}), 0);
    lock_in = 1'b1;
  endtask

  task automatic t_all_codes();
    int hi, lo, ex; bit cp;
    for (int c = 4; c < 64; c++) begin
      cfg_a = 6'(c);
      settle();
      measure(1'b0, hi, lo, cp);
      ex = (c == 7) ? 15 : 2 * c;
      chk((c == 7) ? "R2" : "R1", $sformatf("high half-cycles code %0d", c), hi, ex);
      chk((c == 7) ? "R2" : "R1", $sformatf("low half-cycles code %0d", c), lo, ex);
      chk("R7", $sformatf("copies agree code %0d", c), int'(cp), 1);
    end
  endtask

  task automatic t_banks_indep();
    int hi, lo; bit cp;
    cfg_a = 6'd4; cfg_b = 6'd9;
    settle();
    measure(1'b1, hi, lo, cp);
    chk("R8", "bank B high", hi, 18);
    chk("R8", "bank B low", lo, 18);
    chk("R7", "bank B copies", int'(cp), 1);
    measure(1'b0, hi, lo, cp);
    chk("R8", "bank A high beside B", hi, 8);
  endtask

  task automatic t_illegal();
    int hi, lo, seen; bit cp; logic v, c1;
    cfg_b = 6'd2;
    settle();
    chk("R3", "err_b on code 2", int'(cfg_err_b), 1);
    chk("R8", "err_a untouched", int'(cfg_err_a), 0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b1, v, c1);
      if (out_b != 4'h0) seen++;
    end
    chk("R3", "out_b samples high under illegal code", seen, 0);
    measure(1'b0, hi, lo, cp);
    chk("R8", "bank A high while B illegal", hi, 8);
    cfg_b = 6'd9;
    settle();
    chk("R3", "err_b cleared by legal code", int'(cfg_err_b), 0);
  endtask

  task automatic t_lock_drop();
    int hi, lo, seen; bit cp; logic v, c1;
    cfg_a = 6'd6;
    settle();
    lock_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      step(1'b0, v, c1);
      if ({out_a, out_b} != 8'h0) seen++;
    end
    chk("R4", "samples high without lock", seen, 0);
    lock_in = 1'b1;
    measure(1'b0, hi, lo, cp);
    chk("R5", "first pulse after relock", hi, 12);
    chk("R5", "first low after relock", lo, 12);
  endtask

  task automatic t_midchange();
    int hs, lo, hi2; bit cp; logic v, c1, pv;
    cfg_a = 6'd20;
    settle();
    pv = 1'b1;
    forever begin
      step(1'b0, v, c1);
      if (!pv && v) break;
      pv = v;
    end
    hs = 1;
    forever begin
      step(1'b0, v, c1);
      if (hs == 10) cfg_a = 6'd5;
      if (v) hs++; else break;
    end
    chk("R6", "high phase kept old width", hs, 40);
    lo = 1;
    forever begin
      step(1'b0, v, c1);
      if (!v) lo++; else break;
    end
    chk("R6", "low phase kept old width", lo, 40);
    hi2 = 1;
    forever begin
      step(1'b0, v, c1);
      if (v) hi2++; else break;
    end
    chk("R6", "new code from next period", hi2, 10);
    chk("R6", "no pulse under half min period", int'(hi2 >= 10 && lo >= 10 && hs >= 10), 1);
  endtask

  task automatic t_reset_clears();
    cfg_b = 6'd1;
    settle();
    chk("R3", "err_b on code 1", int'(cfg_err_b), 1);
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk("R9", "err_b after reset", int'(cfg_err_b), 0);
    chk("R4", "outputs during reset", int'({out_a, out_b}), 0);
    cfg_b = 6'd9;
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; lock_in = 1'b0; cfg_a = 6'd4; cfg_b = 6'd9;
    t_reset();
    t_all_codes();
    t_banks_indep();
    t_illegal();
    t_lock_drop();
    t_midchange();
    t_reset_clears();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule